// File: doc/BRIEF.md
# Hardware Thread Context-Switch Scheduler

This block keeps a small table of hardware thread contexts and decides which thread the pipeline runs next. Each table entry holds a program counter, a register window base, a wait tag and a state. New threads enter through a create request. The pipeline reports events for the running thread: it yields, it ends, it misses in the instruction cache, or it reads a register that is not yet full. Fill completions from the instruction cache and update completions from the register file wake every thread blocked on the matching tag.

Ready threads wait in a first-in first-out queue. Whenever no thread is running and the queue holds an entry, the head thread is dispatched and its context appears on the run outputs. The pipeline never stalls for this. A group of threads created since the last family start is tracked, and a completion flag rises once every member has terminated. The table size must be a power of two.

Top module: `thr_sched`

## Requirements
- R1: After reset no thread runs, `cr_ok`, `cr_busy` and `fam_done` are low, and all entries are free.
- R2: A create request takes the lowest-numbered free entry. One edge later `cr_ok` pulses with that index on `cr_tid`, and the new thread joins the tail of the ready queue with the given pc and window.
- R3: A create request made when no entry is free is refused with a one-cycle `cr_busy` pulse. An entry that is terminating does not count as free.
- R4: At an edge where no thread runs and the queue is non-empty, the head thread is dispatched. `run_valid` goes high with its index, pc and window, and at most one thread runs.
- R5: Event kind 0 (yield) with a thread running puts that thread at the queue tail with resume pc `ev_pc`. `run_valid` is low after that edge.
- R6: Event kind 1 (end) terminates the running thread. Its entry becomes free one edge later and can then be created again.
- R7: Event kind 2 (instruction miss) parks the running thread with resume pc `ev_pc` and line tag `ev_tag`. A fill whose tag matches readies every thread parked on it; a fill with a different tag changes nothing.
- R8: Event kind 3 (register not full) parks the running thread with resume pc `ev_pc` and register tag `ev_tag`. A register update with a matching tag readies every such thread; other tags change nothing.
- R9: When several threads become ready at the same edge, they enter the queue in this order: the yielding thread first, then the created thread, then woken threads in ascending index order.
- R10: `fam_done` is high when at least one thread was created since the last `fam_start` and every such thread has ended. `fam_start` clears the member set.
- R11: An event presented while no thread runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_valid | input | 1 | Create request |
| cr_pc | input | PC_W | Start pc of the new thread |
| cr_win | input | WIN_W | Register window base of the new thread |
| cr_ok | output | 1 | Create accepted (one-cycle pulse) |
| cr_busy | output | 1 | Create refused, table full (one-cycle pulse) |
| cr_tid | output | TID_W | Entry index given to the accepted create |
| ev_valid | input | 1 | Event for the running thread |
| ev_kind | input | 2 | 0 yield, 1 end, 2 instruction miss, 3 register not full |
| ev_pc | input | PC_W | Resume pc stored with the event |
| ev_tag | input | TAG_W | Line or register tag the thread waits on |
| fill_valid | input | 1 | Instruction cache line fill completed |
| fill_tag | input | TAG_W | Tag of the filled line |
| upd_valid | input | 1 | Register update completed |
| upd_tag | input | TAG_W | Tag of the updated register |
| fam_start | input | 1 | Clear the family member set |
| run_valid | output | 1 | A thread is running |
| run_tid | output | TID_W | Index of the running thread |
| run_pc | output | PC_W | Pc of the running thread |
| run_win | output | WIN_W | Window base of the running thread |
| fam_done | output | 1 | All family members have ended |

## Verification
Create acknowledgements, the drop of `run_valid` after an event, and the state changes caused by fills and updates all appear at the first rising edge after the stimulus. A dispatch takes one more edge, because it starts from a cycle in which no thread runs. `fam_done` and the run outputs are decoded from registered state, so they are valid right after the edge that changes that state. The bench drives inputs on falling edges and steps a cycle model built from the requirements at each rising edge. It compares every output at the following falling edge, so each result is sampled in the exact cycle it is due.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [2:0] {
        ST_FREE  = 3'd0,
        ST_READY = 3'd1,
        ST_RUN   = 3'd2,
        ST_WIC   = 3'd3,
        ST_WREG  = 3'd4,
        ST_KILL  = 3'd5
    } thr_st_e;

    typedef enum logic [1:0] {
        EV_YIELD = 2'd0,
        EV_END   = 2'd1,
        EV_IMISS = 2'd2,
        EV_RWAIT = 2'd3
    } ev_kind_e;

endpackage

// File: rtl/thr_first_free.sv
// Lowest-index set bit of a mask.
module thr_first_free #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  mask,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |mask;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/thr_wake.sv
// Per-thread tag comparators for cache-fill and register-update wakes.
module thr_wake #(
    parameter int N  = 8,
    parameter int TW = 8
) (
    input  logic [N-1:0]         wait_ic,
    input  logic [N-1:0]         wait_rg,
    input  logic [N-1:0][TW-1:0] tags,
    input  logic                 fill_valid,
    input  logic [TW-1:0]        fill_tag,
    input  logic                 upd_valid,
    input  logic [TW-1:0]        upd_tag,
    output logic [N-1:0]         wake
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign wake[g] = (wait_ic[g] && fill_valid && (tags[g] == fill_tag)) ||
                         (wait_rg[g] && upd_valid  && (tags[g] == upd_tag));
    end
endmodule

// File: rtl/thr_sched.sv
module thr_sched
    import thr_pkg::*;
#(
    parameter int NTHR  = 8,
    parameter int PC_W  = 32,
    parameter int WIN_W = 6,
    parameter int TAG_W = 8,
    localparam int TID_W = $clog2(NTHR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cr_valid,
    input  logic [PC_W-1:0]  cr_pc,
    input  logic [WIN_W-1:0] cr_win,
    output logic             cr_ok,
    output logic             cr_busy,
    output logic [TID_W-1:0] cr_tid,
    input  logic             ev_valid,
    input  logic [1:0]       ev_kind,
    input  logic [PC_W-1:0]  ev_pc,
    input  logic [TAG_W-1:0] ev_tag,
    input  logic             fill_valid,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             upd_valid,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             fam_start,
    output logic             run_valid,
    output logic [TID_W-1:0] run_tid,
    output logic [PC_W-1:0]  run_pc,
    output logic [WIN_W-1:0] run_win,
    output logic             fam_done
);

    typedef struct packed {
        thr_st_e [NTHR-1:0]             st;
        logic [NTHR-1:0][PC_W-1:0]      pc;
        logic [NTHR-1:0][WIN_W-1:0]     win;
        logic [NTHR-1:0][TAG_W-1:0]     tag;
        logic [NTHR-1:0][TID_W-1:0]     fifo;
        logic [TID_W-1:0]               head;
        logic [TID_W-1:0]               tail;
        logic [TID_W:0]                 cnt;
        logic                           run_v;
        logic [TID_W-1:0]               run_id;
        logic [NTHR-1:0]                mem;
        logic                           cr_ok;
        logic                           cr_busy;
        logic [TID_W-1:0]               cr_tid;
    } sched_t;

    sched_t sched_q, sched_d;

    logic [NTHR-1:0] free_vec, run_vec, kill_vec, wic_vec, wrg_vec, alive_vec, wake_vec;
    logic            any_free;
    logic [TID_W-1:0] free_idx;
    logic [TID_W:0]   q_cnt;

    always_comb begin
        for (int i = 0; i < NTHR; i++) begin
            free_vec[i]  = (sched_q.st[i] == ST_FREE);
            run_vec[i]   = (sched_q.st[i] == ST_RUN);
            kill_vec[i]  = (sched_q.st[i] == ST_KILL);
            wic_vec[i]   = (sched_q.st[i] == ST_WIC);
            wrg_vec[i]   = (sched_q.st[i] == ST_WREG);
            alive_vec[i] = !free_vec[i] && !kill_vec[i];
        end
    end

    assign q_cnt = sched_q.cnt;

    thr_first_free #(.N(NTHR), .IW(TID_W)) u_free (
        .mask (free_vec),
        .any  (any_free),
        .idx  (free_idx)
    );

    thr_wake #(.N(NTHR), .TW(TAG_W)) u_wake (
        .wait_ic    (wic_vec),
        .wait_rg    (wrg_vec),
        .tags       (sched_q.tag),
        .fill_valid (fill_valid),
        .fill_tag   (fill_tag),
        .upd_valid  (upd_valid),
        .upd_tag    (upd_tag),
        .wake       (wake_vec)
    );

    always_comb begin
        logic [TID_W-1:0] tl;
        logic [TID_W:0]   pushes;
        logic             pop;
        sched_d         = sched_q;
        sched_d.cr_ok   = 1'b0;
        sched_d.cr_busy = 1'b0;
        tl              = sched_q.tail;
        pushes          = '0;

        // terminated entries are released one edge after the end event
        for (int i = 0; i < NTHR; i++) begin
            if (kill_vec[i]) sched_d.st[i] = ST_FREE;
        end

        // dispatch from the queue head when the pipeline is idle
        pop = !sched_q.run_v && (sched_q.cnt != '0);
        if (pop) begin
            sched_d.run_v  = 1'b1;
            sched_d.run_id = sched_q.fifo[sched_q.head];
            sched_d.st[sched_q.fifo[sched_q.head]] = ST_RUN;
            sched_d.head   = sched_q.head + TID_W'(1);
        end

        // event for the running thread (first in push order)
        if (ev_valid && sched_q.run_v) begin
            sched_d.run_v = 1'b0;
            unique case (ev_kind_e'(ev_kind))
                EV_YIELD: begin
                    sched_d.st[sched_q.run_id] = ST_READY;
                    sched_d.pc[sched_q.run_id] = ev_pc;
                    sched_d.fifo[tl]           = sched_q.run_id;
                    tl     = tl + TID_W'(1);
                    pushes = pushes + (TID_W+1)'(1);
                end
                EV_END: begin
                    sched_d.st[sched_q.run_id] = ST_KILL;
                end
                EV_IMISS: begin
                    sched_d.st[sched_q.run_id]  = ST_WIC;
                    sched_d.pc[sched_q.run_id]  = ev_pc;
                    sched_d.tag[sched_q.run_id] = ev_tag;
                end
                default: begin
                    sched_d.st[sched_q.run_id]  = ST_WREG;
                    sched_d.pc[sched_q.run_id]  = ev_pc;
                    sched_d.tag[sched_q.run_id] = ev_tag;
                end
            endcase
        end

        if (fam_start) sched_d.mem = '0;

        // creation (second in push order)
        if (cr_valid) begin
            if (any_free) begin
                sched_d.st[free_idx]  = ST_READY;
                sched_d.pc[free_idx]  = cr_pc;
                sched_d.win[free_idx] = cr_win;
                sched_d.mem[free_idx] = 1'b1;
                sched_d.fifo[tl]      = free_idx;
                tl     = tl + TID_W'(1);
                pushes = pushes + (TID_W+1)'(1);
                sched_d.cr_ok  = 1'b1;
                sched_d.cr_tid = free_idx;
            end else begin
                sched_d.cr_busy = 1'b1;
            end
        end

        // wakes in ascending index (last in push order)
        for (int i = 0; i < NTHR; i++) begin
            if (wake_vec[i]) begin
                sched_d.st[i]    = ST_READY;
                sched_d.fifo[tl] = TID_W'(i);
                tl     = tl + TID_W'(1);
                pushes = pushes + (TID_W+1)'(1);
            end
        end

        sched_d.tail = tl;
        sched_d.cnt  = sched_q.cnt + pushes - (TID_W+1)'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sched_q <= '0;
        else        sched_q <= sched_d;
    end

    assign cr_ok     = sched_q.cr_ok;
    assign cr_busy   = sched_q.cr_busy;
    assign cr_tid    = sched_q.cr_tid;
    assign run_valid = sched_q.run_v;
    assign run_tid   = sched_q.run_id;
    assign run_pc    = sched_q.pc[sched_q.run_id];
    assign run_win   = sched_q.win[sched_q.run_id];
    assign fam_done  = (|sched_q.mem) && !(|(sched_q.mem & alive_vec));

endmodule

// File: rtl/thr_sched_chk.sv
module thr_sched_chk #(
    parameter int NTHR  = 8,
    parameter int TID_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid,
    input logic             run_valid,
    input logic             cr_ok,
    input logic             cr_busy,
    input logic             any_free,
    input logic [NTHR-1:0]  run_vec,
    input logic [NTHR-1:0]  kill_vec,
    input logic [TID_W:0]   q_cnt
);
    p_ok_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr_ok && cr_busy));

    p_busy_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cr_busy |-> $past(!any_free));

    p_single_runner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(run_vec));

    p_idle_dispatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_valid && q_cnt != '0) |=> run_valid);

    p_event_drops_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && run_valid) |=> !run_valid);

    p_queue_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= (TID_W+1)'(NTHR));

    for (genvar g = 0; g < NTHR; g++) begin : g_kill
        p_kill_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            kill_vec[g] |=> !kill_vec[g]);
    end
endmodule

bind thr_sched thr_sched_chk #(.NTHR(NTHR), .TID_W(TID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .run_valid (run_valid),
    .cr_ok     (cr_ok),
    .cr_busy   (cr_busy),
    .any_free  (any_free),
    .run_vec   (run_vec),
    .kill_vec  (kill_vec),
    .q_cnt     (q_cnt)
);

// File: tb/sim_thr_sched.sv
`timescale 1ns/1ps
module sim_thr_sched;
    localparam int F = 0, RD = 1, RN = 2, WI = 3, WR = 4, K = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cr_valid = 0; logic [31:0] cr_pc = '0; logic [5:0] cr_win = '0;
    logic cr_ok, cr_busy; logic [2:0] cr_tid;
    logic ev_valid = 0; logic [1:0] ev_kind = '0; logic [31:0] ev_pc = '0; logic [7:0] ev_tag = '0;
    logic fill_valid = 0; logic [7:0] fill_tag = '0;
    logic upd_valid = 0;  logic [7:0] upd_tag = '0;
    logic fam_start = 0;
    logic run_valid; logic [2:0] run_tid; logic [31:0] run_pc; logic [5:0] run_win;
    logic fam_done;

    always #2.5 clk = ~clk;

    thr_sched u0 (.*);

    int n_chk = 0, n_fail = 0;

    // requirement-level model
    int          m_st [8];
    logic [31:0] m_pc [8];
    logic [5:0]  m_win[8];
    logic [7:0]  m_tag[8];
    bit          m_mem[8];
    int          mq[$];
    bit          m_rv = 0; int m_rid = 0;
    bit          m_ok = 0, m_busy = 0; int m_tid = 0;

    task automatic check(input bit c, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit m_fam();
        bit anym = 0, live = 0;
        for (int i = 0; i < 8; i++) begin
            if (m_mem[i]) begin
                anym = 1;
                if (m_st[i] != F && m_st[i] != K) live = 1;
            end
        end
        return anym && !live;
    endfunction

    task automatic tick(input string rq);
        int ost[8]; bit orv; int fr;
        ost = m_st; orv = m_rv; m_ok = 0; m_busy = 0;
        for (int i = 0; i < 8; i++) if (ost[i] == K) m_st[i] = F;
        if (!orv && mq.size() > 0) begin
            m_rid = mq.pop_front(); m_rv = 1; m_st[m_rid] = RN;
        end
        if (ev_valid && orv) begin
            m_rv = 0;
            case (ev_kind)
                2'd0: begin m_st[m_rid] = RD; m_pc[m_rid] = ev_pc; mq.push_back(m_rid); end
                2'd1: m_st[m_rid] = K;
                2'd2: begin m_st[m_rid] = WI; m_pc[m_rid] = ev_pc; m_tag[m_rid] = ev_tag; end
                default: begin m_st[m_rid] = WR; m_pc[m_rid] = ev_pc; m_tag[m_rid] = ev_tag; end
            endcase
        end
        if (fam_start) for (int i = 0; i < 8; i++) m_mem[i] = 0;
        if (cr_valid) begin
            fr = -1;
            for (int i = 7; i >= 0; i--) if (ost[i] == F) fr = i;
            if (fr >= 0) begin
                m_st[fr] = RD; m_pc[fr] = cr_pc; m_win[fr] = cr_win; m_mem[fr] = 1;
                mq.push_back(fr); m_ok = 1; m_tid = fr;
            end else m_busy = 1;
        end
        for (int i = 0; i < 8; i++) begin
            if ((ost[i] == WI && fill_valid && m_tag[i] == fill_tag) ||
                (ost[i] == WR && upd_valid && m_tag[i] == upd_tag)) begin
                m_st[i] = RD; mq.push_back(i);
            end
        end
        @(posedge clk); @(negedge clk);
        check(run_valid == m_rv, rq, "run_valid", run_valid, m_rv);
        if (m_rv) begin
            check(run_tid == 3'(m_rid), rq, "run_tid", run_tid, m_rid);
            check(run_pc == m_pc[m_rid] && run_win == m_win[m_rid], rq, "run_pc",
                  run_pc, m_pc[m_rid]);
        end
        check(cr_ok == m_ok && cr_busy == m_busy, rq, "cr_ok/busy",
              {cr_ok, cr_busy}, {m_ok, m_busy});
        if (m_ok) check(cr_tid == 3'(m_tid), rq, "cr_tid", cr_tid, m_tid);
        check(fam_done == m_fam(), rq, "fam_done", fam_done, m_fam());
    endtask

    task automatic idle(input int n, input string rq);
        for (int i = 0; i < n; i++) tick(rq);
    endtask

    task automatic ev(input int k, input logic [31:0] pc, input logic [7:0] tg, input string rq);
        ev_valid = 1; ev_kind = 2'(k); ev_pc = pc; ev_tag = tg;
        tick(rq);
        ev_valid = 0;
    endtask

    task automatic fill(input logic [7:0] tg, input string rq);
        fill_valid = 1; fill_tag = tg; tick(rq); fill_valid = 0;
    endtask

    task automatic upd(input logic [7:0] tg, input string rq);
        upd_valid = 1; upd_tag = tg; tick(rq); upd_valid = 0;
    endtask

    task automatic create(input logic [31:0] pc, input logic [5:0] w, input string rq);
        cr_valid = 1; cr_pc = pc; cr_win = w; tick(rq); cr_valid = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_st[i] = F; m_pc[i] = '0; m_win[i] = '0; m_tag[i] = '0; m_mem[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        check(!run_valid, "R1", "run_valid", run_valid, 0);
        check(!cr_ok && !cr_busy, "R1", "cr flags", {cr_ok, cr_busy}, 0);
        check(!fam_done, "R1", "fam_done", fam_done, 0);

        fam_start = 1; tick("R10"); fam_start = 0;
        // R2 fill the table back to back
        for (int i = 0; i < 8; i++) create(32'h1000 + 32'(i) * 32'h40, 6'(i * 3), "R2");
        // R3 table full
        cr_valid = 1; cr_pc = 32'hdead; idle(2, "R3"); cr_valid = 0;
        idle(2, "R4");
        // R5 yields sweep the whole queue more than once
        for (int k = 0; k < 10; k++) begin
            ev(0, 32'h2000 + 32'(k) * 4, 8'h0, "R5");
            idle(1, "R4");
        end
        // R7 instruction misses on two lines
        for (int k = 0; k < 4; k++) begin
            ev(2, 32'h3000 + 32'(k), (k % 2) ? 8'd9 : 8'd5, "R7");
            idle(1, "R7");
        end
        fill(8'd7, "R7");
        fill(8'd5, "R7");
        idle(3, "R7");
        fill(8'd9, "R7");
        idle(3, "R7");
        // R8 register waits on two tags
        for (int k = 0; k < 4; k++) begin
            ev(3, 32'h4000 + 32'(k), (k % 2) ? 8'd20 : 8'd12, "R8");
            idle(1, "R8");
        end
        upd(8'd33, "R8");
        upd(8'd12, "R8");
        idle(3, "R8");
        upd(8'd20, "R8");
        idle(3, "R8");
        // R6 end every thread, R10 completion follows
        for (int k = 0; k < 14; k++) begin
            if (run_valid) ev(1, 32'h0, 8'h0, "R6");
            idle(1, "R10");
        end
        idle(2, "R10");
        // R11 event with nothing running
        ev(0, 32'h5555, 8'h0, "R11");
        ev(1, 32'h0, 8'h0, "R11");
        idle(1, "R11");
        // R9 simultaneous readiness, entries reused after end (R6)
        fam_start = 1; tick("R10"); fam_start = 0;
        create(32'h6000, 6'd1, "R6");
        idle(1, "R9");
        create(32'h6100, 6'd2, "R9");
        ev(2, 32'h6010, 8'd3, "R9");
        idle(1, "R9");
        create(32'h6200, 6'd3, "R9");
        ev(3, 32'h6110, 8'd4, "R9");
        idle(1, "R9");
        ev_valid = 1; ev_kind = 2'd0; ev_pc = 32'h6210; ev_tag = '0;
        cr_valid = 1; cr_pc = 32'h6300; cr_win = 6'd4;
        fill_valid = 1; fill_tag = 8'd3; upd_valid = 1; upd_tag = 8'd4;
        tick("R9");
        ev_valid = 0; cr_valid = 0; fill_valid = 0; upd_valid = 0;
        for (int k = 0; k < 4; k++) begin
            idle(1, "R9");
            ev(0, 32'h7000 + 32'(k), 8'h0, "R9");
        end
        idle(2, "R9");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule